// File: doc/BRIEF.md
# Sync and Digital-Input Frame Packer

This block assembles the byte stream for one sweep of an analog scanner before the stream goes to a serial transmitter. When a sweep starts it emits zero, one or two framing bytes, then passes on the sample bytes of that sweep. The framing bytes combine a rolling sync count with the value of an 8-bit digital input port. Four framings are available: no framing at all, one byte that packs a variable-width count with the top port bits, one byte that alternates between an odd sync value and the full port value, or a sync byte followed by a port byte on every sweep.

Any outgoing byte equal to zero is sent as 01 unless an allow-zero mode bit is set, so a receiver can treat zero as a gap marker. A run input pauses and resumes the stream. While paused no new byte leaves, and samples are still taken in and dropped. On each resume the sync count starts again from its first value. The output uses a valid/ready handshake. The sample input uses valid with a ready that the block drives.

Top module: `syncFramePacker`

## Requirements
- R1: After reset `outValid` is 0, and with `runEn` low `sampleReady` is 1. The first sync value sent after reset or resume is 1.
- R2: Protocol choice, made from the mode ports: `modeNoSync`=1 gives no framing whatever the other bits are. Otherwise `modeBoth`=1 gives sync-plus-port. Otherwise `modeAlt`=1 gives the alternating framing. All clear gives the packed framing.
- R3: With no framing, a sweep produces only its sample bytes.
- R4: Packed framing sends one byte. Its top N bits hold the low N bits of the count and its low 8-N bits hold `portIn[7:N]`. N is `syncWidth`, clamped to 2 when below 2 and to 8 when above 8.
- R5: In packed framing the count runs 1, 2, … 2^N-1 and then returns to 1.
- R6: Alternating framing sends one byte per sweep: a sync byte on the first sweep after resume and port bytes on every second sweep. The sync values run 1, 3, 5 … 253 and then return to 1.
- R7: Sync-plus-port framing sends the sync byte and then `portIn` each sweep. The sync runs 1 … 254 and then returns to 1.
- R8: When the allow-zero bit latched at the sweep start is 0, every outgoing byte (framing or sample) equal to 00 is sent as 01. When that bit is 1, 00 is sent unchanged.
- R9: Framing bytes come before the sweep's samples. `sampleReady` is low in the cycle a sweep starts and while framing bytes are pending.
- R10: While `outValid`=1 and `outReady`=0, `outValid` and `outData` hold.
- R11: With `runEn` low, `sweepStart` is ignored and no new output byte appears. Samples are accepted (`sampleReady`=1) and dropped.
- R12: On a low-to-high change of `runEn` the count returns to 1 and the alternating framing returns to its sync phase.
- R13: Mode bits, `syncWidth` and `portIn` are sampled only in the sweep-start cycle. Later changes do not alter that sweep's framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | 1 = streaming, 0 = paused |
| sweepStart | input | 1 | One-cycle pulse at the start of a sweep |
| modeNoSync | input | 1 | Select no framing (highest priority) |
| modeBoth | input | 1 | Select sync plus port byte every sweep |
| modeAlt | input | 1 | Select alternating sync/port byte |
| modeAllowZero | input | 1 | 1 = send 00 bytes unchanged |
| syncWidth | input | 4 | Count width N for packed framing |
| portIn | input | 8 | Digital input port value |
| sampleValid | input | 1 | Sample byte offered |
| sampleData | input | 8 | Sample byte |
| sampleReady | output | 1 | Sample byte taken this cycle when valid |
| outValid | output | 1 | Output byte available |
| outData | output | 8 | Output byte |
| outReady | input | 1 | Downstream takes the output byte |

## Verification
The assertions assume that a new `sweepStart` arrives only after the previous sweep's framing bytes have left. They also assume that sample bytes and `outReady` follow the valid/ready rules without glitching inside a cycle. The bench keeps to this by waiting several idle cycles after each sweep before pulsing `sweepStart` again. It holds `sampleValid` until the block takes the byte, and changes inputs only on the falling clock edge. Stalls are produced only by holding `outReady` low while a byte waits. The counter wrap points are reached with long runs of sweeps that carry no samples.

// File: rtl/sfpPkg.sv
package sfpPkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic sweepGo;      // sweep accepted: latch modes, build framing bytes
    logic popFrame;     // move next framing byte into the output register
    logic takeSample;   // move sample byte into the output register
    logic syncRestart;  // stream resumed: count back to first value
  } sfpCtrl_t;

  typedef enum logic [1:0] {
    PROTO_NONE   = 2'd0,
    PROTO_PACKED = 2'd1,
    PROTO_ALT    = 2'd2,
    PROTO_BOTH   = 2'd3
  } sfpProto_e;

endpackage

// File: rtl/sfpControl.sv
module sfpControl
  import sfpPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       runEn,
  input  logic       sweepStart,
  input  logic       sampleValid,
  input  logic       outReady,
  input  logic [1:0] frameLen,
  output sfpCtrl_t   ctrl,
  output logic       sampleReady,
  output logic       outValid
);

  logic       runQ;
  logic [1:0] framePend;
  logic       outValidQ;
  logic       sweepGo;
  logic       loadOk;
  logic       popFrame;
  logic       slotFree;
  logic       takeSample;

  always_comb begin
    sweepGo    = sweepStart & runEn;
    loadOk     = ~outValidQ | outReady;
    popFrame   = runEn & ~sweepGo & (framePend != 2'd0) & loadOk;
    slotFree   = runEn & ~sweepGo & (framePend == 2'd0) & loadOk;
    takeSample = slotFree & sampleValid;
  end

  assign sampleReady      = ~runEn | slotFree;
  assign outValid         = outValidQ;
  assign ctrl.sweepGo     = sweepGo;
  assign ctrl.popFrame    = popFrame;
  assign ctrl.takeSample  = takeSample;
  assign ctrl.syncRestart = runEn & ~runQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ      <= 1'b0;
      framePend <= 2'd0;
      outValidQ <= 1'b0;
    end else begin
      runQ <= runEn;
      if (!runEn)        framePend <= 2'd0;
      else if (sweepGo)  framePend <= frameLen;
      else if (popFrame) framePend <= framePend - 2'd1;

      if (popFrame | takeSample) outValidQ <= 1'b1;
      else if (outReady)         outValidQ <= 1'b0;
    end
  end

endmodule

// File: rtl/sfpDatapath.sv
module sfpDatapath
  import sfpPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WID_W  = 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  sfpCtrl_t          ctrl,
  input  logic              modeNoSync,
  input  logic              modeBoth,
  input  logic              modeAlt,
  input  logic              modeAllowZero,
  input  logic [WID_W-1:0]  syncWidth,
  input  logic [DATA_W-1:0] portIn,
  input  logic [DATA_W-1:0] sampleData,
  output logic [1:0]        frameLen,
  output logic [DATA_W-1:0] outData,
  output logic              zeroOk
);

  localparam logic [WID_W-1:0]  MIN_W    = WID_W'(2);
  localparam logic [WID_W-1:0]  MAX_W    = WID_W'(DATA_W);
  localparam logic [DATA_W-1:0] ONE      = DATA_W'(1);
  localparam logic [DATA_W-1:0] ALT_MAX  = DATA_W'((1 << DATA_W) - 3);
  localparam logic [DATA_W-1:0] BOTH_MAX = DATA_W'((1 << DATA_W) - 2);

  sfpProto_e         protoSel;
  logic [WID_W-1:0]  widthEff;
  logic [WID_W-1:0]  shAmt;
  logic [DATA_W:0]   packedMax;
  logic [DATA_W-1:0] packedByte;

  logic [DATA_W-1:0] syncCnt;
  logic              altPhase;
  logic [DATA_W-1:0] curCnt;
  logic              curPhase;

  logic [DATA_W-1:0] fb0, fb1, nextCnt;
  logic              nextPhase;

  logic [DATA_W-1:0] fbQ0, fbQ1;
  logic              allowZeroQ;
  logic [DATA_W-1:0] outDataQ;

  // Protocol priority: no-sync, then both, then alternate, then packed
  always_comb begin
    if (modeNoSync)    protoSel = PROTO_NONE;
    else if (modeBoth) protoSel = PROTO_BOTH;
    else if (modeAlt)  protoSel = PROTO_ALT;
    else               protoSel = PROTO_PACKED;
  end

  always_comb begin
    if (syncWidth < MIN_W)      widthEff = MIN_W;
    else if (syncWidth > MAX_W) widthEff = MAX_W;
    else                        widthEff = syncWidth;
    shAmt     = MAX_W - widthEff;
    packedMax = ({{DATA_W{1'b0}}, 1'b1} << widthEff) - (DATA_W+1)'(1);
  end

  // A resume in the same cycle as a sweep start uses the restart values
  assign curCnt   = ctrl.syncRestart ? ONE : syncCnt;
  assign curPhase = ctrl.syncRestart ? 1'b0 : altPhase;

  assign packedByte = (curCnt << shAmt) | (portIn >> widthEff);

  always_comb begin
    fb0       = '0;
    fb1       = '0;
    nextCnt   = curCnt;
    nextPhase = curPhase;
    frameLen  = 2'd0;
    unique case (protoSel)
      PROTO_NONE: begin
        frameLen = 2'd0;
      end
      PROTO_PACKED: begin
        frameLen = 2'd1;
        fb0      = packedByte;
        nextCnt  = ({1'b0, curCnt} >= packedMax) ? ONE : curCnt + ONE;
      end
      PROTO_ALT: begin
        frameLen  = 2'd1;
        nextPhase = ~curPhase;
        if (!curPhase) begin
          fb0     = curCnt;
          nextCnt = (curCnt >= ALT_MAX) ? ONE : curCnt + DATA_W'(2);
        end else begin
          fb0 = portIn;
        end
      end
      PROTO_BOTH: begin
        frameLen = 2'd2;
        fb0      = curCnt;
        fb1      = portIn;
        nextCnt  = (curCnt >= BOTH_MAX) ? ONE : curCnt + ONE;
      end
      default: frameLen = 2'd0;
    endcase
  end

  function automatic logic [DATA_W-1:0] fixZero(input logic [DATA_W-1:0] b,
                                                input logic allow);
    return (!allow && b == '0) ? ONE : b;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncCnt    <= ONE;
      altPhase   <= 1'b0;
      fbQ0       <= '0;
      fbQ1       <= '0;
      allowZeroQ <= 1'b0;
      outDataQ   <= '0;
    end else begin
      if (ctrl.sweepGo) begin
        syncCnt    <= nextCnt;
        altPhase   <= nextPhase;
        fbQ0       <= fb0;
        fbQ1       <= fb1;
        allowZeroQ <= modeAllowZero;
      end else begin
        if (ctrl.syncRestart) begin
          syncCnt  <= ONE;
          altPhase <= 1'b0;
        end
        if (ctrl.popFrame) begin
          fbQ0 <= fbQ1;
        end
      end
      if (ctrl.popFrame)        outDataQ <= fixZero(fbQ0, allowZeroQ);
      else if (ctrl.takeSample) outDataQ <= fixZero(sampleData, allowZeroQ);
    end
  end

  assign outData = outDataQ;
  assign zeroOk  = allowZeroQ;

endmodule

// File: rtl/syncFramePacker.sv
module syncFramePacker
  import sfpPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WID_W  = 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              sweepStart,
  input  logic              modeNoSync,
  input  logic              modeBoth,
  input  logic              modeAlt,
  input  logic              modeAllowZero,
  input  logic [WID_W-1:0]  syncWidth,
  input  logic [DATA_W-1:0] portIn,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  output logic              sampleReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  input  logic              outReady
);

  sfpCtrl_t   ctrl;
  logic [1:0] frameLen;
  logic       zeroOk;

  sfpControl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .runEn       (runEn),
    .sweepStart  (sweepStart),
    .sampleValid (sampleValid),
    .outReady    (outReady),
    .frameLen    (frameLen),
    .ctrl        (ctrl),
    .sampleReady (sampleReady),
    .outValid    (outValid)
  );

  sfpDatapath #(.DATA_W(DATA_W), .WID_W(WID_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctrl          (ctrl),
    .modeNoSync    (modeNoSync),
    .modeBoth      (modeBoth),
    .modeAlt       (modeAlt),
    .modeAllowZero (modeAllowZero),
    .syncWidth     (syncWidth),
    .portIn        (portIn),
    .sampleData    (sampleData),
    .frameLen      (frameLen),
    .outData       (outData),
    .zeroOk        (zeroOk)
  );

endmodule

// File: rtl/sfpChecker.sv
module sfpChecker #(
  parameter int DATA_W = 8
)(
  input logic              clk,
  input logic              rstN,
  input logic              runEn,
  input logic              sweepStart,
  input logic              sampleReady,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              outReady,
  input logic              zeroOk
);

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData))); // R10

  AST_NO_ZERO_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !zeroOk) |-> (outData != '0)); // R8

  AST_PAUSE_TAKES_SAMPLES: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> sampleReady); // R11

  AST_PAUSE_NO_NEW_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !outValid) |=> !outValid); // R11

  AST_SWEEP_BLOCKS_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    (sweepStart && runEn) |-> !sampleReady); // R9

endmodule

bind syncFramePacker sfpChecker #(.DATA_W(DATA_W)) u_sfpChecker (
  .clk         (clk),
  .rstN        (rstN),
  .runEn       (runEn),
  .sweepStart  (sweepStart),
  .sampleReady (sampleReady),
  .outValid    (outValid),
  .outData     (outData),
  .outReady    (outReady),
  .zeroOk      (zeroOk)
);

// File: tb/syncFramePacker_bench.sv
module syncFramePacker_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic       runEn, sweepStart;
  logic       modeNoSync, modeBoth, modeAlt, modeAllowZero;
  logic [3:0] syncWidth;
  logic [7:0] portIn;
  logic       sampleValid;
  logic [7:0] sampleData;
  logic       sampleReady, outValid, outReady;
  logic [7:0] outData;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [7:0] cap [0:599];
  int capN = 0;

  always #10 clk = ~clk;

  syncFramePacker u_syncFramePacker (
    .clk(clk), .rstN(rstN), .runEn(runEn), .sweepStart(sweepStart),
    .modeNoSync(modeNoSync), .modeBoth(modeBoth), .modeAlt(modeAlt),
    .modeAllowZero(modeAllowZero), .syncWidth(syncWidth), .portIn(portIn),
    .sampleValid(sampleValid), .sampleData(sampleData),
    .sampleReady(sampleReady), .outValid(outValid), .outData(outData),
    .outReady(outReady)
  );

  // Record every byte taken by the downstream side
  always @(posedge clk) begin
    if (rstN && outValid && outReady && capN < 600) begin
      cap[capN] = outData;
      capN = capN + 1;
    end
  end

  // Stimulus vectors: {mode nibble {noSync,both,alt,allowZero}, width,
  // port, sample, frame length, frame byte 0, frame byte 1, sample out, pad}
  localparam logic [63:0] VEC [12] = '{
    64'h03FF50013F005000,  // R4 packed N=3
    64'h04F050011F005000,  // R4 packed N=4
    64'h08AA500101005000,  // R4 packed N=8, port unused
    64'h0100500140005000,  // R4 N=1 clamped to 2
    64'h0C33500101005000,  // R4 N=12 clamped to 8
    64'h235A500101005000,  // R6 alternating, first sweep is sync
    64'h435A5002015A5000,  // R7 sync plus port
    64'h835A500000005000,  // R3 no framing
    64'hC35A500000005000,  // R2 no-sync overrides both
    64'h635A5002015A5000,  // R2 both overrides alternate
    64'h4300000201010100,  // R8 zeros replaced
    64'h5300000201000000   // R8 zeros allowed
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic restart();
    @(negedge clk) runEn = 1'b0;
    @(negedge clk) runEn = 1'b1;
  endtask

  task automatic setMode(input logic [3:0] m, input logic [3:0] w, input logic [7:0] p);
    {modeNoSync, modeBoth, modeAlt, modeAllowZero} = m;
    syncWidth = w;
    portIn    = p;
  endtask

  task automatic doSweep(input int nSamp, input logic [7:0] v);
    @(negedge clk) sweepStart = 1'b1;
    @(negedge clk) sweepStart = 1'b0;
    for (int i = 0; i < nSamp; i++) begin
      sampleValid = 1'b1;
      sampleData  = v;
      do @(posedge clk); while (!sampleReady);
      @(negedge clk) sampleValid = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    check(0, "watchdog", 0, 1);
    finish();
  end

  initial begin
    rstN = 1'b0; runEn = 1'b0; sweepStart = 1'b0;
    setMode(4'h0, 4'd3, 8'h00);
    sampleValid = 1'b0; sampleData = 8'h00; outReady = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1 reset outValid", outValid, 0);
    check(sampleReady == 1'b1, "R1 paused sampleReady", sampleReady, 1);

    // Table walk
    for (int k = 0; k < 12; k++) begin
      logic [63:0] vv;
      int expLen;
      vv = VEC[k];
      setMode(vv[63:60], vv[59:56], vv[55:48]);
      restart();
      capN = 0;
      doSweep(1, vv[47:40]);
      expLen = int'(vv[39:32]);
      check(capN == expLen + 1, $sformatf("R3/R9 vec%0d byte count", k), capN, expLen + 1);
      if (expLen >= 1) check(cap[0] == vv[31:24], $sformatf("R1/R4 vec%0d frame0", k), cap[0], vv[31:24]);
      if (expLen >= 2) check(cap[1] == vv[23:16], $sformatf("R7 vec%0d frame1", k), cap[1], vv[23:16]);
      check(cap[expLen] == vv[15:8], $sformatf("R9/R8 vec%0d sample", k), cap[expLen], vv[15:8]);
    end

    // R5: packed N=2 counts 1,2,3,1
    setMode(4'h0, 4'd2, 8'h00);
    restart();
    capN = 0;
    for (int i = 0; i < 4; i++) doSweep(0, 8'h00);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] e;
      e = 8'((i % 3) + 1) << 6;
      check(cap[i] == e, "R5 packed wrap", cap[i], e);
    end

    // R6: alternating run past the 253 wrap
    setMode(4'h2, 4'd3, 8'h77);
    restart();
    capN = 0;
    for (int i = 0; i < 260; i++) doSweep(0, 8'h00);
    begin
      int c = 1;
      bit ph = 0;
      int bad = 0;
      for (int i = 0; i < 260; i++) begin
        int e;
        if (!ph) begin
          e = c;
          c = (c >= 253) ? 1 : c + 2;
        end else e = 8'h77;
        ph = ~ph;
        if (cap[i] != 8'(e)) begin
          if (bad == 0) check(0, "R6 alternating sequence", cap[i], e);
          bad++;
        end
      end
      if (bad == 0) check(1, "R6 alternating sequence", 0, 0);
      check(cap[252] == 8'd253, "R6 last sync", cap[252], 253);
      check(cap[254] == 8'd1, "R6 wrap to 1", cap[254], 1);
    end

    // R7: sync plus port run past the 254 wrap
    setMode(4'h4, 4'd3, 8'h77);
    restart();
    capN = 0;
    for (int i = 0; i < 256; i++) doSweep(0, 8'h00);
    begin
      int bad = 0;
      for (int i = 0; i < 256; i++) begin
        int e;
        e = (i % 254) + 1;
        if (cap[2*i] != 8'(e) || cap[2*i+1] != 8'h77) begin
          if (bad == 0) check(0, "R7 sync sequence", cap[2*i], e);
          bad++;
        end
      end
      if (bad == 0) check(1, "R7 sync sequence", 0, 0);
      check(cap[2*253] == 8'd254, "R7 last sync", cap[2*253], 254);
      check(cap[2*254] == 8'd1, "R7 wrap to 1", cap[2*254], 1);
    end

    // R12: resume restarts the count and the alternating phase
    setMode(4'h4, 4'd3, 8'h5A);
    restart();
    for (int i = 0; i < 3; i++) doSweep(0, 8'h00);
    restart();
    capN = 0;
    doSweep(0, 8'h00);
    check(cap[0] == 8'h01, "R12 count restart", cap[0], 1);
    setMode(4'h2, 4'd3, 8'h5A);
    restart();
    doSweep(0, 8'h00);
    restart();
    capN = 0;
    doSweep(0, 8'h00);
    check(cap[0] == 8'h01, "R12 phase restart", cap[0], 1);

    // R11: paused stream ignores sweeps and drops samples
    @(negedge clk) runEn = 1'b0;
    capN = 0;
    @(negedge clk) sweepStart = 1'b1; sampleValid = 1'b1; sampleData = 8'h50;
    check(sampleReady == 1'b1, "R11 paused takes sample", sampleReady, 1);
    @(negedge clk) sweepStart = 1'b0; sampleValid = 1'b0;
    repeat (5) @(negedge clk);
    check(capN == 0, "R11 paused no output", capN, 0);
    check(outValid == 1'b0, "R11 paused outValid", outValid, 0);

    // R13: mode change after sweep start does not alter framing
    setMode(4'h4, 4'd3, 8'h5A);
    restart();
    capN = 0;
    @(negedge clk) sweepStart = 1'b1;
    @(negedge clk) sweepStart = 1'b0; modeNoSync = 1'b1; portIn = 8'h11;
    repeat (5) @(negedge clk);
    check(capN == 2, "R13 framing kept", capN, 2);
    check(cap[1] == 8'h5A, "R13 port latched", cap[1], 8'h5A);

    // R10: backpressure holds the byte
    setMode(4'h4, 4'd3, 8'h5A);
    restart();
    capN = 0;
    outReady = 1'b0;
    @(negedge clk) sweepStart = 1'b1;
    @(negedge clk) sweepStart = 1'b0;
    repeat (3) @(negedge clk);
    check(outValid == 1'b1 && outData == 8'h01, "R10 byte waiting", outData, 1);
    repeat (3) @(negedge clk);
    check(outValid == 1'b1 && outData == 8'h01, "R10 byte held", outData, 1);
    outReady = 1'b1;
    repeat (4) @(negedge clk);
    check(capN == 2 && cap[1] == 8'h5A, "R10 release order", cap[1], 8'h5A);

    // R9: sample offered with the sweep start still follows the framing
    restart();
    capN = 0;
    @(negedge clk) sweepStart = 1'b1; sampleValid = 1'b1; sampleData = 8'h50;
    @(negedge clk) sweepStart = 1'b0;
    do @(posedge clk); while (!sampleReady);
    @(negedge clk) sampleValid = 1'b0;
    repeat (4) @(negedge clk);
    check(capN == 3 && cap[2] == 8'h50 && cap[0] == 8'h01, "R9 framing first", cap[2], 8'h50);

    finish();
  end

endmodule